// File: doc/BRIEF.md
# Level-Gated Interrupt Aggregator with APB Register File

This block gathers a configurable number of level-sensitive interrupt lines, from 2 to 64, and merges them into a single processor interrupt. Each line passes through a two-stage synchronizer. It then passes a per-line gate made of an enable bit and a separate mask bit. The lines that pass the gate appear in a read-only pending view, and their OR, registered, drives the processor interrupt.

Software reaches the controls through an APB slave. Each control is 64 bits wide and is split into a low word (lines 0..31) and a high word (lines 32..63). The controls are the enable word pair, the mask word pair and the pending word pair.

Storage exists only for the lines that are implemented. Bits above the configured count read back as zero, so software can find the line count by writing all ones to the enable words and reading them back. The handler scans the pending words and services each set bit.

Top module: `irq_hub_apb`

## Requirements
- R1: After reset every enable bit and every mask bit is 0, both pending words read 0, and `irq_o` is 0.
- R2: The enable words sit at byte offset 0x00 (lines 0..31, bit n = line n) and 0x04 (lines 32..63, bit n = line 32+n). A write in the APB access phase stores the implemented bits, and a read returns them.
- R3: Enable and mask bits for lines at or above `NUM_SRC` read as 0, even after all ones have been written to them.
- R4: The mask words sit at 0x08 and 0x0C, with the same bit layout as the enable words. A mask bit of 1 blocks its line and a mask bit of 0 lets it through.
- R5: Pending bit n, read at 0x30 (lines 0..31) or 0x34 (lines 32..63), is 1 exactly when synchronized line n is high, its enable bit is 1 and its mask bit is 0. A change on an input line shows in the pending bit after two rising clock edges.
- R6: The pending words are read-only. A write to 0x30 or 0x34 changes no enable bit, no mask bit and no pending bit.
- R7: `irq_o` is the OR of all pending bits, delayed by one register. It rises on the third rising edge after a lone input rises, and not earlier.
- R8: A read from any other offset returns 0. `pready` is always 1 and `pslverr` is always 0.
- R9: Inputs are levels. A pending bit stays set for as long as its line stays high while enabled and unmasked. It clears two edges after the line falls, and no register has to be cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, tied high |
| pslverr | output | 1 | APB error, tied low |
| src_i | input | NUM_SRC | Level interrupt inputs |
| irq_o | output | 1 | Merged processor interrupt |

## Verification
The bench builds the block with `NUM_SRC` = 40. With that value the high words are only partly implemented, so the same all-ones write shows stored bits 32..39 and absent bits 40..63 in one read. The bench drives lines in both halves (3 and 35), which checks the high-word pending path and how enable and mask combine within it. An 8-bit address bus lets the undefined-offset reads reach the top of the map at 0xFC.

// File: rtl/irqh_pkg.sv
package irqh_pkg;
  localparam int unsigned MAX_SRC  = 64;
  localparam int unsigned DATA_W   = 32;
  localparam logic [7:0] OFS_EN_LO  = 8'h00;
  localparam logic [7:0] OFS_EN_HI  = 8'h04;
  localparam logic [7:0] OFS_MSK_LO = 8'h08;
  localparam logic [7:0] OFS_MSK_HI = 8'h0C;
  localparam logic [7:0] OFS_PND_LO = 8'h30;
  localparam logic [7:0] OFS_PND_HI = 8'h34;

  // Ones in the positions of implemented lines.
  function automatic logic [MAX_SRC-1:0] impl_bits(input int unsigned n);
    logic [MAX_SRC-1:0] m;
    for (int i = 0; i < MAX_SRC; i++) m[i] = (i < n);
    return m;
  endfunction

  // Pending = synchronized level AND enabled AND not masked.
  function automatic logic [MAX_SRC-1:0] gate_bits(input logic [MAX_SRC-1:0] lvl,
                                                   input logic [MAX_SRC-1:0] en,
                                                   input logic [MAX_SRC-1:0] msk);
    return lvl & en & ~msk;
  endfunction
endpackage

// File: rtl/irqh_sync.sv
module irqh_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_i;
      stage2_q <= stage1_q;
    end
  end

  assign q_o = stage2_q;
endmodule

// File: rtl/irqh_regs.sv
module irqh_regs #(
  parameter int unsigned NUM_SRC = 40
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we_en_lo,
  input  logic                      we_en_hi,
  input  logic                      we_msk_lo,
  input  logic                      we_msk_hi,
  input  logic [irqh_pkg::DATA_W-1:0] wdata,
  output logic [irqh_pkg::MAX_SRC-1:0] en_o,
  output logic [irqh_pkg::MAX_SRC-1:0] msk_o
);
  localparam int unsigned DW = irqh_pkg::DATA_W;

  for (genvar i = 0; i < irqh_pkg::MAX_SRC; i++) begin : g_bit
    if (i < NUM_SRC) begin : g_impl
      logic en_q, msk_q, we_e, we_m;
      if (i < DW) begin : g_lo
        assign we_e = we_en_lo;
        assign we_m = we_msk_lo;
      end else begin : g_hi
        assign we_e = we_en_hi;
        assign we_m = we_msk_hi;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          en_q  <= 1'b0;
          msk_q <= 1'b0;
        end else begin
          if (we_e) en_q  <= wdata[i % DW];
          if (we_m) msk_q <= wdata[i % DW];
        end
      end
      assign en_o[i]  = en_q;
      assign msk_o[i] = msk_q;
    end else begin : g_absent
      assign en_o[i]  = 1'b0;
      assign msk_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irqh_gate.sv
module irqh_gate (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [irqh_pkg::MAX_SRC-1:0] lvl_i,
  input  logic [irqh_pkg::MAX_SRC-1:0] en_i,
  input  logic [irqh_pkg::MAX_SRC-1:0] msk_i,
  output logic [irqh_pkg::MAX_SRC-1:0] pend_o,
  output logic                         any_pend_o,
  output logic                         irq_o
);
  logic irq_q;

  assign pend_o     = irqh_pkg::gate_bits(lvl_i, en_i, msk_i);
  assign any_pend_o = |pend_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= any_pend_o;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_hub_apb.sv
module irq_hub_apb #(
  parameter int unsigned NUM_SRC = 40,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [ADDR_W-1:0]  paddr,
  input  logic [31:0]        pwdata,
  output logic [31:0]        prdata,
  output logic               pready,
  output logic               pslverr,
  input  logic [NUM_SRC-1:0] src_i,
  output logic               irq_o
);
  import irqh_pkg::*;
  localparam int unsigned MS = MAX_SRC;
  localparam int unsigned DW = DATA_W;

  logic [NUM_SRC-1:0] src_sync;
  logic [MS-1:0]      lvl, en_q, msk_q, pend;
  logic               any_pend;
  logic               wr_access;
  logic               hit_en_lo, hit_en_hi, hit_msk_lo, hit_msk_hi, hit_pnd_lo, hit_pnd_hi;

  // Address decode, shared by the write enables and the read mux.
  assign hit_en_lo  = (paddr == ADDR_W'(OFS_EN_LO));
  assign hit_en_hi  = (paddr == ADDR_W'(OFS_EN_HI));
  assign hit_msk_lo = (paddr == ADDR_W'(OFS_MSK_LO));
  assign hit_msk_hi = (paddr == ADDR_W'(OFS_MSK_HI));
  assign hit_pnd_lo = (paddr == ADDR_W'(OFS_PND_LO));
  assign hit_pnd_hi = (paddr == ADDR_W'(OFS_PND_HI));
  assign wr_access  = psel & penable & pwrite;

  irqh_sync #(.W(NUM_SRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(src_i), .q_o(src_sync)
  );

  if (NUM_SRC < MS) begin : g_pad
    assign lvl = {{(MS-NUM_SRC){1'b0}}, src_sync};
  end else begin : g_full
    assign lvl = src_sync;
  end

  irqh_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .we_en_lo (wr_access & hit_en_lo),
    .we_en_hi (wr_access & hit_en_hi),
    .we_msk_lo(wr_access & hit_msk_lo),
    .we_msk_hi(wr_access & hit_msk_hi),
    .wdata(pwdata),
    .en_o(en_q), .msk_o(msk_q)
  );

  irqh_gate u_gate (
    .clk(clk), .rst_n(rst_n),
    .lvl_i(lvl), .en_i(en_q), .msk_i(msk_q),
    .pend_o(pend), .any_pend_o(any_pend), .irq_o(irq_o)
  );

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      unique case (1'b1)
        hit_en_lo:  prdata = en_q[DW-1:0];
        hit_en_hi:  prdata = en_q[MS-1:DW];
        hit_msk_lo: prdata = msk_q[DW-1:0];
        hit_msk_hi: prdata = msk_q[MS-1:DW];
        hit_pnd_lo: prdata = pend[DW-1:0];
        hit_pnd_hi: prdata = pend[MS-1:DW];
        default:    prdata = '0;
      endcase
    end
  end

  assign pready  = 1'b1;
  assign pslverr = 1'b0;
endmodule

// File: rtl/irqh_chk.sv
module irqh_chk #(
  parameter int unsigned NUM_SRC = 40,
  parameter int unsigned ADDR_W  = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         psel,
  input logic                         penable,
  input logic                         pwrite,
  input logic [ADDR_W-1:0]            paddr,
  input logic [31:0]                  prdata,
  input logic                         pready,
  input logic                         pslverr,
  input logic                         irq_o,
  input logic [irqh_pkg::MAX_SRC-1:0] en_q,
  input logic [irqh_pkg::MAX_SRC-1:0] msk_q,
  input logic [irqh_pkg::MAX_SRC-1:0] pend,
  input logic                         any_pend
);
  localparam logic [63:0] IMPL = irqh_pkg::impl_bits(NUM_SRC);

  AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~en_q) == '0); // R5
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & msk_q) == '0); // R4
  AST_HI_READ_TRIM: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !pwrite && (paddr == ADDR_W'(8'h04) || paddr == ADDR_W'(8'h0C)))
      |-> ((prdata & ~IMPL[63:32]) == '0)); // R3
  AST_RO_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pwrite && (paddr == ADDR_W'(8'h30) || paddr == ADDR_W'(8'h34)))
      |=> ($stable(en_q) && $stable(msk_q))); // R6
  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (irq_o == $past(any_pend))); // R7
  AST_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    pready && !pslverr); // R8
endmodule

bind irq_hub_apb irqh_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .prdata(prdata), .pready(pready), .pslverr(pslverr),
  .irq_o(irq_o), .en_q(en_q), .msk_q(msk_q), .pend(pend), .any_pend(any_pend)
);

// File: tb/sim_irq_hub_apb.sv
`timescale 1ns/1ps
module sim_irq_hub_apb;
  localparam int unsigned NSRC = 40;
  localparam int unsigned AW   = 8;
  localparam logic [31:0] HI_IMPL = 32'((64'd1 << (NSRC - 32)) - 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [AW-1:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic pready, pslverr, irq_o;
  logic [NSRC-1:0] src = '0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_hub_apb #(.NUM_SRC(NSRC), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .src_i(src), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1; d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    apb_rd(a, d);
    check(req, d, exp);
  endtask

  task automatic set_src(input logic [NSRC-1:0] v);
    @(negedge clk); src = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    rd_chk("R1 en_lo", 8'h00, 0); rd_chk("R1 en_hi", 8'h04, 0);
    rd_chk("R1 msk_lo", 8'h08, 0); rd_chk("R1 msk_hi", 8'h0C, 0);
    rd_chk("R1 pnd_lo", 8'h30, 0); rd_chk("R1 pnd_hi", 8'h34, 0);
  endtask

  task automatic t_storage;
    apb_wr(8'h00, 32'hA5A5_0F0F); rd_chk("R2 en_lo pattern", 8'h00, 32'hA5A5_0F0F);
    apb_wr(8'h00, '1); apb_wr(8'h04, '1);
    rd_chk("R2 en_lo ones", 8'h00, 32'hFFFF_FFFF);
    rd_chk("R3 en_hi trimmed", 8'h04, HI_IMPL);
    apb_wr(8'h08, '1); apb_wr(8'h0C, '1);
    rd_chk("R4 msk_lo ones", 8'h08, 32'hFFFF_FFFF);
    rd_chk("R3 msk_hi trimmed", 8'h0C, HI_IMPL);
    apb_wr(8'h08, 0); apb_wr(8'h0C, 0);
    rd_chk("R4 msk_lo cleared", 8'h08, 0);
  endtask

  task automatic t_gating;
    logic [NSRC-1:0] v;
    v = '0; v[3] = 1; v[35] = 1;
    set_src(v);
    rd_chk("R5 pnd_lo bit3", 8'h30, 32'h8);
    rd_chk("R5 pnd_hi bit35", 8'h34, 32'h8);
    check("R7 irq high", {31'b0, irq_o}, 1);
    apb_wr(8'h08, 32'h8);
    rd_chk("R4 masked bit3", 8'h30, 0);
    rd_chk("R4 hi unaffected", 8'h34, 32'h8);
    apb_wr(8'h04, 32'h0);
    rd_chk("R5 disabled bit35", 8'h34, 0);
    @(negedge clk);
    check("R7 irq low when nothing passes", {31'b0, irq_o}, 0);
    apb_wr(8'h04, '1); apb_wr(8'h08, 0);
    set_src('0);
  endtask

  task automatic t_ro;
    logic [NSRC-1:0] v;
    v = '0; v[1] = 1;
    apb_wr(8'h0C, 32'h2);
    set_src(v);
    apb_wr(8'h30, 32'h0); apb_wr(8'h34, 32'hFFFF_FFFF);
    rd_chk("R6 en_lo kept", 8'h00, 32'hFFFF_FFFF);
    rd_chk("R6 msk_hi kept", 8'h0C, 32'h2);
    rd_chk("R6 pnd_lo kept", 8'h30, 32'h2);
    rd_chk("R6 pnd_hi kept", 8'h34, 0);
    apb_wr(8'h0C, 0);
    set_src('0);
  endtask

  task automatic t_irq_timing;
    logic [NSRC-1:0] v;
    v = '0; v[0] = 1;
    @(negedge clk); src = v;
    @(posedge clk); @(posedge clk); #1;
    check("R7 irq not yet after 2 edges", {31'b0, irq_o}, 0);
    @(posedge clk); #1;
    check("R7 irq after 3 edges", {31'b0, irq_o}, 1);
  endtask

  task automatic t_level;
    repeat (20) @(negedge clk);
    rd_chk("R9 held while high", 8'h30, 32'h1);
    check("R9 irq held", {31'b0, irq_o}, 1);
    @(negedge clk); src = '0;
    @(posedge clk); @(posedge clk); #1;
    rd_chk("R9 cleared on drop", 8'h30, 0);
  endtask

  task automatic t_undef;
    rd_chk("R8 read 0x10", 8'h10, 0);
    rd_chk("R8 read 0x38", 8'h38, 0);
    rd_chk("R8 read 0xFC", 8'hFC, 0);
    check("R8 pready", {31'b0, pready}, 1);
    check("R8 pslverr", {31'b0, pslverr}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_storage();
    t_gating();
    t_ro();
    t_irq_timing();
    t_level();
    t_undef();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule